// File: doc/BRIEF.md
# Programmable Two-Port Parallel Interface

This block connects a processor bus to two parallel device ports of `W` bits each. The processor uses a chip select, a two-bit register address, and separate read and write strobes to reach four registers: the port A data register, the port B data register, a control register and a status register. The chip's pad ring builds the bidirectional processor data bus from three vectors. These are the incoming bus value `d_in`, the outgoing value `d_out`, and a drive enable `d_oe`. When `d_oe` is low the bus is released to high impedance.

Bit 0 of the control register sets the direction of port A and bit 1 sets the direction of port B. An output port drives its data register onto its pins. An input port copies its pins into its data register on every clock. The processor can therefore make either port a data, command or status channel at run time.

The status register is read-only and holds two flags. The first flags new input on port A. The second shows that a byte written to port B is still waiting for the device to acknowledge it. Port pins leave the block as separate input, output and output-enable vectors.

Top module: `two_port_pio`

## Requirements
- R1: While `cs` is low, `d_oe` is 0 whatever the values of `rd`, `wr` and `rs`.
- R2: While `cs` and `rd` are both high, `d_oe` is 1 in the same cycle and `d_out` shows the register picked by `rs`. The `rs` codes are 00 for port A, 01 for port B, 10 for control and 11 for status.
- R3: A write takes effect on the rising clock edge where `cs` and `wr` are both high, and `d_in` is stored. All 8 bits of the control register read back as written.
- R4: Control bit 0 sets the direction of port A and bit 1 sets the direction of port B, with 1 meaning output. An output port drives all-ones on its output-enable vector and holds its data register on its output vector, which changes only when the processor writes that port.
- R5: An input port drives all-zeros on its output-enable vector. It stores its pins on every clock edge, so a read returns the pin value present at the previous edge. A processor write to an input port is ignored.
- R6: The status register is read-only. A write with `rs` = 11 changes neither the status flags nor the control register.
- R7: Status bit 0 is set on an edge where port A is an input and its pins differ from the port A register. It is cleared on an edge where port A is read. It is never set while port A is an output.
- R8: Status bit 1 is set on an edge that writes port B while port B is an output. It is cleared on an edge where `ack_b` is high. If both happen on the same edge, the set wins. Status bits above bit 1 read 0.
- R9: While `rst_n` is low, all registers and flags are cleared, both ports are inputs, and `d_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select |
| rs | input | 2 | Register select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| d_in | input | W | Value arriving from the processor bus |
| d_out | output | W | Value returned to the processor bus |
| d_oe | output | 1 | Bus drive enable (0 = high impedance) |
| pa_in | input | W | Port A pin inputs |
| pa_out | output | W | Port A pin outputs |
| pa_oe | output | W | Port A pin output enables |
| pb_in | input | W | Port B pin inputs |
| pb_out | output | W | Port B pin outputs |
| pb_oe | output | W | Port B pin output enables |
| ack_b | input | 1 | Device acknowledge that clears the port B flag |

## Verification
Read results are combinational, so `d_oe` and `d_out` are due in the same cycle that `cs` and `rd` rise. The bench drives the strobes on the falling edge and samples 1 ns later. Writes, pin sampling and flag updates each pass through one register. Their effects are due just after the next rising edge, and the bench checks them only after that edge or with a following read cycle. Clearing a flag on a port A read happens on the edge that ends the read, so the bench confirms the clear with a separate status read afterwards.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [1:0] {
    SEL_PORT_A = 2'b00,
    SEL_PORT_B = 2'b01,
    SEL_CTRL   = 2'b10,
    SEL_STAT   = 2'b11
  } reg_sel_e;

  localparam int CTRL_DIR_A  = 0;
  localparam int CTRL_DIR_B  = 1;
  localparam int STAT_A_NEW  = 0;
  localparam int STAT_B_FULL = 1;
  localparam int NUM_PORTS   = 2;
  localparam int NUM_FLAGS   = 2;
endpackage

// File: rtl/pio_decode.sv
module pio_decode
  import pio_pkg::*;
(
  input  logic       cs,
  input  logic [1:0] rs,
  input  logic       rd,
  input  logic       wr,
  output logic       wr_a,
  output logic       wr_b,
  output logic       wr_ctrl,
  output logic       rd_a,
  output logic       bus_oe
);
  logic     wr_cyc, rd_cyc;
  reg_sel_e sel;

  always_comb begin
    sel     = reg_sel_e'(rs);
    wr_cyc  = cs & wr;
    rd_cyc  = cs & rd;
    wr_a    = wr_cyc && (sel == SEL_PORT_A);
    wr_b    = wr_cyc && (sel == SEL_PORT_B);
    wr_ctrl = wr_cyc && (sel == SEL_CTRL);
    rd_a    = rd_cyc && (sel == SEL_PORT_A);
    bus_oe  = rd_cyc;
  end
endmodule

// File: rtl/pio_port.sv
module pio_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dir_out,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] reg_q,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      reg_q <= '0;
    else if (!dir_out)
      reg_q <= pin_in;
    else if (wr_en)
      reg_q <= wr_data;
  end

  assign pin_out = reg_q;
  assign pin_oe  = {W{dir_out}};
endmodule

// File: rtl/pio_status.sv
module pio_status
  import pio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] set_i,
  input  logic [NUM_FLAGS-1:0] clr_i,
  output logic [NUM_FLAGS-1:0] flags_q
);
  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)
        flags_q[f] <= 1'b0;
      else if (set_i[f])
        flags_q[f] <= 1'b1;
      else if (clr_i[f])
        flags_q[f] <= 1'b0;
    end
  end
endmodule

// File: rtl/two_port_pio.sv
module two_port_pio
  import pio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs,
  input  logic [1:0]   rs,
  input  logic         rd,
  input  logic         wr,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out,
  output logic         d_oe,
  input  logic [W-1:0] pa_in,
  output logic [W-1:0] pa_out,
  output logic [W-1:0] pa_oe,
  input  logic [W-1:0] pb_in,
  output logic [W-1:0] pb_out,
  output logic [W-1:0] pb_oe,
  input  logic         ack_b
);
  localparam int PAD = W - NUM_FLAGS;

  logic                 wr_a, wr_b, wr_ctrl, rd_a, bus_oe;
  logic [W-1:0]         ctrl_q;
  logic [W-1:0]         status_word;
  logic [NUM_FLAGS-1:0] status_q, flag_set, flag_clr;

  logic [NUM_PORTS-1:0] port_dir, port_wr;
  logic [W-1:0]         port_pin [NUM_PORTS];
  logic [W-1:0]         port_q   [NUM_PORTS];
  logic [W-1:0]         port_out [NUM_PORTS];
  logic [W-1:0]         port_oe  [NUM_PORTS];

  pio_decode u_dec (
    .cs(cs), .rs(rs), .rd(rd), .wr(wr),
    .wr_a(wr_a), .wr_b(wr_b), .wr_ctrl(wr_ctrl),
    .rd_a(rd_a), .bus_oe(bus_oe)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= d_in;
  end

  assign port_dir = {ctrl_q[CTRL_DIR_B], ctrl_q[CTRL_DIR_A]};
  assign port_wr  = {wr_b, wr_a};
  assign port_pin[0] = pa_in;
  assign port_pin[1] = pb_in;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    pio_port #(.W(W)) u_port (
      .clk(clk), .rst_n(rst_n),
      .dir_out(port_dir[p]), .wr_en(port_wr[p]), .wr_data(d_in),
      .pin_in(port_pin[p]), .reg_q(port_q[p]),
      .pin_out(port_out[p]), .pin_oe(port_oe[p])
    );
  end

  assign pa_out = port_out[0];
  assign pa_oe  = port_oe[0];
  assign pb_out = port_out[1];
  assign pb_oe  = port_oe[1];

  always_comb begin
    flag_set = '0;
    flag_clr = '0;
    flag_set[STAT_A_NEW]  = !port_dir[0] && (pa_in != port_q[0]);
    flag_clr[STAT_A_NEW]  = rd_a;
    flag_set[STAT_B_FULL] = wr_b && port_dir[1];
    flag_clr[STAT_B_FULL] = ack_b;
  end

  pio_status u_stat (
    .clk(clk), .rst_n(rst_n),
    .set_i(flag_set), .clr_i(flag_clr), .flags_q(status_q)
  );

  assign status_word = {{PAD{1'b0}}, status_q};

  always_comb begin
    d_out = '0;
    if (bus_oe) begin
      unique case (reg_sel_e'(rs))
        SEL_PORT_A: d_out = port_q[0];
        SEL_PORT_B: d_out = port_q[1];
        SEL_CTRL:   d_out = ctrl_q;
        SEL_STAT:   d_out = status_word;
      endcase
    end
  end
  assign d_oe = bus_oe;
endmodule

// File: rtl/pio_checker.sv
module pio_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cs,
  input logic [1:0]   rs,
  input logic         wr,
  input logic [W-1:0] d_in,
  input logic         d_oe,
  input logic         ack_b,
  input logic [W-1:0] pa_oe,
  input logic [W-1:0] pb_oe,
  input logic [W-1:0] pa_out,
  input logic [1:0]   flags
);
  AST_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> !d_oe); // R1
  AST_DIR_FOLLOWS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && rs == 2'b10) |=> (pa_oe == {W{$past(d_in[0])}} && pb_oe == {W{$past(d_in[1])}})); // R4
  AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_oe[0] && !(cs && wr && rs == 2'b00) && !(cs && wr && rs == 2'b10)) |=> $stable(pa_out)); // R4
  AST_STATUS_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && rs == 2'b11) |=> ($stable(pa_oe) && $stable(pb_oe))); // R6
  AST_FULL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && rs == 2'b01 && pb_oe[0]) |=> flags[1]); // R8
  AST_FULL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_b && !(cs && wr && rs == 2'b01)) |=> !flags[1]); // R8
  AST_NEW_IDLE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_oe[0] && !flags[0]) |=> !flags[0]); // R7
endmodule

bind two_port_pio pio_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .rs(rs), .wr(wr), .d_in(d_in),
  .d_oe(d_oe), .ack_b(ack_b), .pa_oe(pa_oe), .pb_oe(pb_oe),
  .pa_out(pa_out), .flags(status_q)
);

// File: tb/sim_two_port_pio.sv
module sim_two_port_pio;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cs = 1'b0, rd = 1'b0, wr = 1'b0, ack_b = 1'b0;
  logic [1:0]   rs = 2'b00;
  logic [W-1:0] d_in = '0, pa_in = '0, pb_in = '0;
  logic [W-1:0] d_out, pa_out, pa_oe, pb_out, pb_oe;
  logic         d_oe;
  int           n_run = 0, n_fail = 0;
  bit           done = 1'b0;
  logic [W-1:0] rv;

  always #2 clk = ~clk;

  two_port_pio #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rs(rs), .rd(rd), .wr(wr),
    .d_in(d_in), .d_out(d_out), .d_oe(d_oe),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .ack_b(ack_b)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [W-1:0] v);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; rs = a; d_in = v;
    @(posedge clk); #1;
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [W-1:0] v);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; rs = a;
    #1;
    v = d_out;
    check("R2 bus driven", {7'd0, d_oe}, 8'd1);
    @(posedge clk); #1;
    cs = 1'b0; rd = 1'b0;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R9 oe A", pa_oe, 8'h00);
    check("R9 oe B", pb_oe, 8'h00);
    check("R9 bus", {7'd0, d_oe}, 8'd0);
    @(negedge clk); rst_n = 1'b1;

    bus_read(2'b10, rv); check("R9 ctrl", rv, 8'h00);
    bus_read(2'b11, rv); check("R9 status", rv, 8'h00);

    // R1: deselected reads leave bus released
    for (int a = 0; a < 4; a++) begin
      @(negedge clk); cs = 1'b0; rd = 1'b1; wr = (a == 3); rs = 2'(a);
      #1; check("R1 released", {7'd0, d_oe}, 8'd0);
    end
    @(negedge clk); rd = 1'b0; wr = 1'b0;

    // R3/R4: control sweep
    for (int c = 0; c < 4; c++) begin
      logic [W-1:0] cv;
      cv = 8'(c) | 8'(c * 8'h34 + 8'h50) & 8'hFC;
      bus_write(2'b10, cv);
      check("R4 oe A", pa_oe, {W{cv[0]}});
      check("R4 oe B", pb_oe, {W{cv[1]}});
      bus_read(2'b10, rv); check("R3 ctrl readback", rv, cv);
    end

    // R5: input sampling on both ports
    bus_write(2'b10, 8'h00);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); pa_in = 8'(i * 37 + 3); pb_in = 8'(255 - i * 13);
      @(posedge clk);
      bus_read(2'b00, rv); check("R5 sample A", rv, 8'(i * 37 + 3));
      bus_read(2'b01, rv); check("R5 sample B", rv, 8'(255 - i * 13));
    end
    bus_write(2'b00, 8'h5A);
    bus_read(2'b00, rv); check("R5 write ignored A", rv, pa_in);
    bus_write(2'b01, 8'hA5);
    bus_read(2'b01, rv); check("R5 write ignored B", rv, pb_in);
    bus_read(2'b11, rv); check("R8 no flag on input B", rv & 8'h02, 8'h00);

    // R7: new-data flag on port A
    bus_read(2'b00, rv);
    bus_read(2'b11, rv); check("R7 clear after read", rv & 8'h01, 8'h00);
    @(negedge clk); pa_in = 8'h11;
    @(posedge clk);
    bus_read(2'b11, rv); check("R7 set on change", rv & 8'h01, 8'h01);
    bus_read(2'b00, rv); check("R7 data", rv, 8'h11);
    bus_read(2'b11, rv); check("R7 cleared by read", rv & 8'h01, 8'h00);

    // R4: output mode
    bus_write(2'b10, 8'h03);
    for (int i = 0; i < 16; i++) begin
      bus_write(2'b00, 8'(i * 29 + 7));
      check("R4 out A", pa_out, 8'(i * 29 + 7));
      bus_write(2'b01, 8'(i * 71 + 1));
      check("R4 out B", pb_out, 8'(i * 71 + 1));
      @(negedge clk); pa_in = 8'(i); pb_in = 8'(~i);
      @(posedge clk); #1;
      check("R4 hold A", pa_out, 8'(i * 29 + 7));
    end
    bus_read(2'b11, rv); check("R7 no flag when output", rv & 8'h01, 8'h00);

    // R8: full flag
    bus_read(2'b11, rv); check("R8 full set", rv, 8'h02);
    @(negedge clk); ack_b = 1'b1; @(posedge clk); #1; ack_b = 1'b0;
    bus_read(2'b11, rv); check("R8 full cleared", rv, 8'h00);
    @(negedge clk); ack_b = 1'b1; cs = 1'b1; wr = 1'b1; rs = 2'b01; d_in = 8'h77;
    @(posedge clk); #1; ack_b = 1'b0; cs = 1'b0; wr = 1'b0;
    bus_read(2'b11, rv); check("R8 set wins", rv, 8'h02);

    // R6: status read-only
    bus_write(2'b11, 8'hFC);
    bus_read(2'b11, rv); check("R6 status kept", rv, 8'h02);
    bus_read(2'b10, rv); check("R6 ctrl kept", rv, 8'h03);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule